// File: doc/BRIEF.md
# Dual-Port Buffer Doorbell and Window Decoder

This block connects the local side of a PCI bridge to a signal processor. The two exchange bulk data through an external 16-bit dual-port buffer of 16K words, so neither side ever arbitrates for the other's bus. The block's first job is combinational. It turns the bridge's byte-style local address into a buffer word address and an active-low chip select. The select is asserted only when the top address bit matches a configured window value and a local access is in progress.

Its second job is to carry notifications between the two clock domains. When the bridge has filled the buffer, it raises its user-output line. The block then raises the processor's interrupt request. When the processor has filled the buffer, it raises a flag. The block then raises the bridge's user-input line, which the bridge polls.

Each doorbell synchronizes its source through a flop chain into the destination clock and fires on the rising edge. It holds a pending bit until the destination side clears it. The two doorbells are independent of each other. Each clock domain has its own synchronous active-high reset.

Top module: `dpbuf_doorbell_ctrl`

## Requirements
- R1: `buf_addr` equals `l_addr[14:1]` at all times. Local byte address bit 0 has no port and cannot affect the buffer, so the even offsets 0x0000..0x7FFE map to words 0..16383.
- R2: `buf_cs_n` is 0 only while `l_access` is 1, `l_rst` is 0 and `l_addr[15]` equals the parameter `WIN_SEL` (default 0). Otherwise it is 1.
- R3: A 0-to-1 change of `l_user_out` made between `d_clk` edges raises `d_irq` at the third rising `d_clk` edge after the change, and not earlier.
- R4: Once raised, `d_irq` stays 1 until `d_ack` is sampled 1 at a `d_clk` edge. It is 0 after that edge, unless R7 applies.
- R5: A 0-to-1 change of `d_flag` made between `l_clk` edges raises `l_user_in` at the third rising `l_clk` edge after the change, and not earlier.
- R6: Once raised, `l_user_in` stays 1 until `l_clr` is sampled 1 at an `l_clk` edge. It is 0 after that edge, unless R7 applies.
- R7: When a clear is sampled at the same edge where a new synchronized rising edge sets the pending bit, the pending bit stays 1.
- R8: A source held at 1 triggers only once. After the clear, the destination line stays 0 for as long as the source remains 1.
- R9: While `d_rst` is 1, `d_irq` is 0 after the next `d_clk` edge. While `l_rst` is 1, `l_user_in` is 0 after the next `l_clk` edge and `buf_cs_n` is 1.
- R10: The two doorbells do not interact. Setting or clearing one leaves the other's line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| l_clk | input | 1 | Bridge local-bus clock |
| l_rst | input | 1 | Synchronous active-high reset, local domain |
| d_clk | input | 1 | Processor clock |
| d_rst | input | 1 | Synchronous active-high reset, processor domain |
| l_addr | input | 15 | Local address bits 15..1 |
| l_access | input | 1 | High while a local access is in progress |
| l_user_out | input | 1 | Bridge doorbell toward the processor |
| l_clr | input | 1 | Bridge clears its pending user-input |
| l_user_in | output | 1 | Doorbell from the processor to the bridge |
| buf_addr | output | 14 | Buffer word address |
| buf_cs_n | output | 1 | Buffer chip select, active low |
| d_flag | input | 1 | Processor doorbell toward the bridge |
| d_ack | input | 1 | Processor clears its pending interrupt |
| d_irq | output | 1 | Interrupt request to the processor |

## Verification
The address and chip-select results are combinational and are due in the same cycle as the address. The bench drives them at a falling edge and samples a few time units later.

Each doorbell result is due at the third rising destination edge after the source changes. The bench drives the source at a falling destination edge, samples once after the second rising edge to confirm the line has not risen early, and samples again after the third.

Clears take effect at the first rising edge that samples them. The same-edge race is built by raising the clear exactly in the cycle before that third edge.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
    localparam int LA_W    = 16;
    localparam int WORD_AW = LA_W - 2;
    localparam int SYNC_N  = 2;

    typedef enum logic {
        DB_IDLE = 1'b0,
        DB_PEND = 1'b1
    } db_state_t;

    typedef struct packed {
        logic [WORD_AW-1:0] word;
        logic               cs_n;
    } buf_sel_t;

    function automatic logic win_hit(input logic sel, input logic win);
        return sel == win;
    endfunction
endpackage

// File: rtl/dbl_sync.sv
module dbl_sync #(
    parameter int STAGES = dbl_pkg::SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q[i] <= 1'b0;
                else     q[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q[i] <= 1'b0;
                else     q[i] <= q[i-1];
            end
        end
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/dbl_doorbell.sv
module dbl_doorbell
    import dbl_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic src_async,
    input  logic clr,
    output logic pend
);
    logic      src_s;
    logic      src_d;
    logic      rise;
    db_state_t state;

    dbl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (src_async),
        .dout (src_s)
    );

    always_ff @(posedge clk) begin
        if (rst) src_d <= 1'b0;
        else     src_d <= src_s;
    end

    assign rise = src_s & ~src_d;

    always_ff @(posedge clk) begin
        if (rst)       state <= DB_IDLE;
        else if (rise) state <= DB_PEND;
        else if (clr)  state <= DB_IDLE;
    end

    assign pend = (state == DB_PEND);

    // R7
    edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> pend);

    // R4 R6
    clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !rise) |=> !pend);

    // R8
    quiet_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!rise && !clr) |=> $stable(pend));

    // R3 R5
    set_needs_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(src_s));
endmodule

// File: rtl/dbl_addr_dec.sv
module dbl_addr_dec
    import dbl_pkg::*;
#(
    parameter logic WIN_SEL = 1'b0
) (
    input  logic            rst,
    input  logic [LA_W-1:1] addr,
    input  logic            access,
    output buf_sel_t        sel
);
    always_comb begin
        sel.word = addr[WORD_AW:1];
        sel.cs_n = rst | ~(access & win_hit(addr[LA_W-1], WIN_SEL));
    end
endmodule

// File: rtl/dpbuf_doorbell_ctrl.sv
module dpbuf_doorbell_ctrl
    import dbl_pkg::*;
#(
    parameter logic WIN_SEL     = 1'b0,
    parameter int   SYNC_STAGES = SYNC_N
) (
    input  logic               l_clk,
    input  logic               l_rst,
    input  logic               d_clk,
    input  logic               d_rst,
    input  logic [LA_W-1:1]    l_addr,
    input  logic               l_access,
    input  logic               l_user_out,
    input  logic               l_clr,
    output logic               l_user_in,
    output logic [WORD_AW-1:0] buf_addr,
    output logic               buf_cs_n,
    input  logic               d_flag,
    input  logic               d_ack,
    output logic               d_irq
);
    buf_sel_t sel;

    dbl_addr_dec #(.WIN_SEL(WIN_SEL)) u_dec (
        .rst    (l_rst),
        .addr   (l_addr),
        .access (l_access),
        .sel    (sel)
    );

    assign buf_addr = sel.word;
    assign buf_cs_n = sel.cs_n;

    dbl_doorbell #(.SYNC_STAGES(SYNC_STAGES)) u_to_dsp (
        .clk       (d_clk),
        .rst       (d_rst),
        .src_async (l_user_out),
        .clr       (d_ack),
        .pend      (d_irq)
    );

    dbl_doorbell #(.SYNC_STAGES(SYNC_STAGES)) u_to_bridge (
        .clk       (l_clk),
        .rst       (l_rst),
        .src_async (d_flag),
        .clr       (l_clr),
        .pend      (l_user_in)
    );

    // R2
    cs_in_window_chk: assert property (@(posedge l_clk) disable iff (l_rst)
        !buf_cs_n |-> (l_access && l_addr[LA_W-1] == WIN_SEL));

    // R1
    word_addr_chk: assert property (@(posedge l_clk) disable iff (l_rst)
        buf_addr == l_addr[WORD_AW:1]);
endmodule

// File: tb/tb_dpbuf_doorbell_ctrl.sv
module tb_dpbuf_doorbell_ctrl;
    localparam int LCLK_P = 10;
    localparam int DCLK_P = 14;

    logic        l_clk = 1'b0, d_clk = 1'b0;
    logic        l_rst = 1'b1, d_rst = 1'b1;
    logic [15:1] l_addr = '0;
    logic        l_access = 1'b0, l_user_out = 1'b0, l_clr = 1'b0;
    logic        d_flag = 1'b0, d_ack = 1'b0;
    logic        l_user_in, buf_cs_n, d_irq;
    logic [13:0] buf_addr;

    int  n_run = 0, n_fail = 0;
    bit  done = 0;
    bit  exp_irq = 0, exp_uin = 0;

    always #(LCLK_P/2) l_clk = ~l_clk;
    always #(DCLK_P/2) d_clk = ~d_clk;

    dpbuf_doorbell_ctrl dut (
        .l_clk(l_clk), .l_rst(l_rst), .d_clk(d_clk), .d_rst(d_rst),
        .l_addr(l_addr), .l_access(l_access), .l_user_out(l_user_out),
        .l_clr(l_clr), .l_user_in(l_user_in), .buf_addr(buf_addr),
        .buf_cs_n(buf_cs_n), .d_flag(d_flag), .d_ack(d_ack), .d_irq(d_irq)
    );

    function automatic logic [13:0] exp_word(input logic [15:1] a);
        return a[14:1];
    endfunction

    function automatic logic exp_cs(input logic [15:1] a, input logic acc,
                                    input logic rst);
        return !(acc && !rst && a[15] == 1'b0);
    endfunction

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_both(input string req);
        chk(req, d_irq, exp_irq);
        chk(req, l_user_in, exp_uin);
    endtask

    // bridge -> DSP doorbell; optionally keep the source high
    task automatic ring_dsp(input bit hold);
        @(negedge d_clk) l_user_out = 1'b1;
        repeat (2) @(posedge d_clk);
        @(negedge d_clk);
        chk("R3 early", d_irq, exp_irq);
        @(posedge d_clk);
        @(negedge d_clk);
        exp_irq = 1;
        chk("R3", d_irq, 1);
        if (!hold) begin
            l_user_out = 1'b0;
            repeat (3) @(negedge d_clk);
        end
    endtask

    task automatic ring_bridge(input bit hold);
        @(negedge l_clk) d_flag = 1'b1;
        repeat (2) @(posedge l_clk);
        @(negedge l_clk);
        chk("R5 early", l_user_in, exp_uin);
        @(posedge l_clk);
        @(negedge l_clk);
        exp_uin = 1;
        chk("R5", l_user_in, 1);
        if (!hold) begin
            d_flag = 1'b0;
            repeat (3) @(negedge l_clk);
        end
    endtask

    task automatic ack_dsp();
        @(negedge d_clk) d_ack = 1'b1;
        @(negedge d_clk) d_ack = 1'b0;
        exp_irq = 0;
        chk("R4", d_irq, 0);
    endtask

    task automatic clr_bridge();
        @(negedge l_clk) l_clr = 1'b1;
        @(negedge l_clk) l_clr = 1'b0;
        exp_uin = 0;
        chk("R6", l_user_in, 0);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (4) @(negedge l_clk);
        repeat (4) @(negedge d_clk);
        // R9 reset state
        l_access = 1'b1;
        #1 chk("R9 cs in reset", buf_cs_n, 1);
        chk_both("R9 reset");
        l_access = 1'b0;
        @(negedge l_clk) l_rst = 1'b0;
        @(negedge d_clk) d_rst = 1'b0;
        repeat (3) @(negedge l_clk);

        // R1 R2 directed corners
        foreach (l_addr[i]) begin end
        begin
            logic [15:1] corners [5] = '{15'h0000, 15'h3FFF, 15'h4000, 15'h7FFF, 15'h2AAA};
            for (int k = 0; k < 5; k++) begin
                for (int acc = 0; acc < 2; acc++) begin
                    @(negedge l_clk);
                    l_addr = corners[k];
                    l_access = acc[0];
                    #1;
                    chk("R1", buf_addr, exp_word(l_addr));
                    chk("R2", buf_cs_n, exp_cs(l_addr, l_access, 1'b0));
                end
            end
        end
        // R1 R2 random
        for (int k = 0; k < 300; k++) begin
            @(negedge l_clk);
            l_addr = 15'($urandom);
            l_access = 1'($urandom);
            #1;
            chk("R1", buf_addr, exp_word(l_addr));
            chk("R2", buf_cs_n, exp_cs(l_addr, l_access, 1'b0));
        end
        @(negedge l_clk) l_access = 1'b0;

        // R3 R4 R5 R6 R10 directed
        ring_dsp(0);
        chk("R10 bridge untouched", l_user_in, 0);
        ring_bridge(0);
        chk("R10 dsp untouched", d_irq, 1);
        ack_dsp();
        chk("R10 after ack", l_user_in, 1);
        clr_bridge();
        chk_both("R10 both clear");

        // R7 same-edge race, DSP side (pending already set)
        ring_dsp(0);
        @(negedge d_clk) l_user_out = 1'b1;
        repeat (2) @(posedge d_clk);
        @(negedge d_clk) d_ack = 1'b1;
        @(posedge d_clk);
        @(negedge d_clk) d_ack = 1'b0;
        chk("R7 dsp", d_irq, 1);
        l_user_out = 1'b0;
        repeat (3) @(negedge d_clk);
        chk("R7 dsp held", d_irq, 1);
        ack_dsp();

        // R7 race, bridge side
        ring_bridge(0);
        @(negedge l_clk) d_flag = 1'b1;
        repeat (2) @(posedge l_clk);
        @(negedge l_clk) l_clr = 1'b1;
        @(posedge l_clk);
        @(negedge l_clk) l_clr = 1'b0;
        chk("R7 bridge", l_user_in, 1);
        d_flag = 1'b0;
        repeat (3) @(negedge l_clk);
        clr_bridge();

        // R8 level held does not retrigger
        ring_dsp(1);
        ack_dsp();
        repeat (6) @(negedge d_clk);
        chk("R8 dsp", d_irq, 0);
        l_user_out = 1'b0;
        ring_bridge(1);
        clr_bridge();
        repeat (6) @(negedge l_clk);
        chk("R8 bridge", l_user_in, 0);
        d_flag = 1'b0;
        repeat (4) @(negedge l_clk);
        repeat (4) @(negedge d_clk);

        // random doorbell traffic, R10 cross-check each step
        for (int k = 0; k < 40; k++) begin
            case ($urandom % 4)
                0: ring_dsp(0);
                1: ack_dsp();
                2: ring_bridge(0);
                default: clr_bridge();
            endcase
            chk_both("R10 random");
        end

        // R9 reset with both pending
        if (!exp_irq) ring_dsp(0);
        if (!exp_uin) ring_bridge(0);
        @(negedge l_clk) begin l_rst = 1'b1; l_access = 1'b1; l_addr = '0; end
        #1 chk("R9 cs", buf_cs_n, 1);
        @(negedge l_clk);
        chk("R9 uin", l_user_in, 0);
        @(negedge d_clk) d_rst = 1'b1;
        @(negedge d_clk);
        chk("R9 irq", d_irq, 0);
        l_rst = 1'b0; d_rst = 1'b0;
        #1 chk("R2 after reset", buf_cs_n, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(LCLK_P * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule